// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Framing

This block sends and receives asynchronous serial frames on a pair of single-wire lines. A transmit holding buffer takes one byte at a time from a valid/ready write port and feeds a shift register that drives the line. A receive holding buffer presents each completed frame on a valid/ready read port, together with the ninth received bit and per-frame error flags. Level-style interrupt requests are provided for "transmit buffer empty" and "receive buffer full", each gated by its own enable.

One set of control pins selects the frame shape for both directions: 7, 8 or 9 data bits, a parity mode, and one or two transmitted stop bits. The pin `cfg_xbit_psel0` has two uses. In nine-bit mode it is the value of the ninth transmitted data bit. In the other modes it is the low bit of the parity selector. The bit rate comes from `tick16`, a one-cycle enable pulse at sixteen times the bit rate that is generated outside the block. The receiver checks a single stop bit whatever stop count is programmed, so a remote sender using one stop bit is always accepted.

Back-pressure rules: a write is accepted in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is the transmit-buffer-empty flag, and a write that is not accepted has no effect. A read is accepted in any cycle where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high and no read is accepted, `rx_data` and its status bits hold. A frame that completes while the buffer is still full is dropped.

Top module: `uft_xcvr`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits LSB first (7 bits when `cfg_nine`=0 and `cfg_len8`=0, 8 bits when `cfg_nine`=0 and `cfg_len8`=1, 9 bits when `cfg_nine`=1), then the optional parity bit, then high stop bits. Each bit lasts 16 `tick16` pulses.
- R2: When `cfg_nine`=0, {`cfg_psel1`,`cfg_xbit_psel0`} selects parity: 00 none, 01 odd (the total count of ones is odd), 10 even, 11 a constant 1. Parity covers the data bits only. In nine-bit mode no parity bit is sent or checked.
- R3: In nine-bit mode the ninth transmitted bit equals `cfg_xbit_psel0`. `rx_bit9` shows the ninth received bit of the frame in the buffer, and it is 0 in the other modes.
- R4: The transmitter sends two stop bits when `cfg_stop2`=1 and one stop bit otherwise. The receiver accepts a frame followed by a single stop bit in either setting.
- R5: `tx_ready` is high when the transmit buffer is empty. An accepted write clears it, and it rises again when the byte moves into the shift register. `tx_irq` is high exactly while `tx_ready` and `tx_ien` are both high.
- R6: `rx_valid` rises when a frame is loaded and falls after an accepted read. `rx_irq` is high exactly while `rx_valid` and `rx_ien` are both high.
- R7: A start bit that is high again when sampled at its middle is discarded, and no frame is received.
- R8: `rx_err_frame` is set for a loaded frame whose stop bit is sampled low.
- R9: `rx_err_parity` is set for a loaded frame whose received parity bit does not match the selected mode.
- R10: A frame that completes while `rx_valid` is high and no read is accepted in that cycle is dropped. The old data stays, and `rx_err_overrun` is set until the next frame is loaded. A read accepted in the same cycle as completion lets the new frame load with no overrun.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfg_nine | input | 1 | Nine-data-bit mode |
| cfg_len8 | input | 1 | 8 data bits (1) or 7 (0) when not in nine-bit mode |
| cfg_psel1 | input | 1 | Parity selector high bit |
| cfg_xbit_psel0 | input | 1 | Ninth transmit bit in nine-bit mode, else parity selector low bit |
| cfg_stop2 | input | 1 | Transmit two stop bits |
| tx_ien | input | 1 | Transmit interrupt enable |
| rx_ien | input | 1 | Receive interrupt enable |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Write request |
| tx_ready | output | 1 | Transmit buffer empty |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Read request |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_err_frame | output | 1 | Stop bit sampled low |
| rx_err_parity | output | 1 | Parity mismatch |
| rx_err_overrun | output | 1 | A frame was dropped on a full buffer |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Two events can fall in the same cycle: a frame finishing in the receiver and a read that empties the holding buffer. The bench provokes this by injecting a second frame while the first waits unread, and by sweeping a one-cycle read pulse across about fifty cycles around the end of that second frame. Each outcome must be one of two cases: either the new frame is loaded with no overrun, or the buffer is empty with the overrun flag set. The sweep must show both cases, with the switch happening only once. A read in the completion cycle must give the first case.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int DATA_W    = 8;
  localparam int MAX_FRAME = 12;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ONE  = 2'b11
  } par_e;

  typedef struct packed {
    logic nine;
    logic len8;
    logic psel1;
    logic xbit_psel0;
    logic stop2;
  } fmt_t;

  function automatic logic [3:0] data_len(fmt_t f);
    return f.nine ? 4'd9 : (f.len8 ? 4'd8 : 4'd7);
  endfunction

  function automatic logic par_on(fmt_t f);
    return !f.nine && ({f.psel1, f.xbit_psel0} != 2'b00);
  endfunction

  function automatic logic par_bit(fmt_t f, logic [DATA_W-1:0] d);
    logic x;
    x = f.len8 ? ^d : ^d[DATA_W-2:0];
    case (par_e'({f.psel1, f.xbit_psel0}))
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uft_tx.sv
module uft_tx
  import uft_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  fmt_t              fmt,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_full,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int SUBW = $clog2(OVS);

  logic [MAX_FRAME-1:0] sh, fr;
  logic [3:0]           left, nb, dl;
  logic [SUBW-1:0]      sub;
  logic [DATA_W:0]      d9;
  logic                 pon;

  always_comb begin
    dl  = data_len(fmt);
    pon = par_on(fmt);
    d9  = {fmt.xbit_psel0, buf_data};
    fr  = '1;
    fr[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (i < int'(dl)) fr[i+1] = d9[i];
    end
    if (pon) fr[dl+4'd1] = par_bit(fmt, buf_data);
    nb = 4'd1 + dl + {3'b000, pon} + (fmt.stop2 ? 4'd2 : 4'd1);
  end

  assign take = !busy && buf_full;
  assign txd  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      sub  <= '0;
      busy <= 1'b0;
    end else if (take) begin
      sh   <= fr;
      left <= nb;
      sub  <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (sub == SUBW'(OVS-1)) begin
        sub  <= '0;
        sh   <= {1'b1, sh[MAX_FRAME-1:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uft_rx.sv
module uft_rx
  import uft_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  fmt_t            fmt,
  input  logic            rxd,
  output logic            done,
  output logic [DATA_W:0] data,
  output logic            ferr,
  output logic            perr
);
  localparam int SUBW = $clog2(OVS);
  localparam int CW   = SUBW + 4;
  localparam int MID  = OVS / 2 - 1;

  logic [SYNC-1:0] sy;
  logic            rxs, active, pb, pon;
  logic [CW-1:0]   cnt;
  logic [3:0]      idx, dl;

  assign rxs = sy[SYNC-1];
  assign idx = cnt[CW-1:SUBW];
  assign dl  = data_len(fmt);
  assign pon = par_on(fmt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '1;
    else        sy <= {sy[SYNC-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      data   <= '0;
      pb     <= 1'b0;
      done   <= 1'b0;
      ferr   <= 1'b0;
      perr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (tick && !rxs) begin
          active <= 1'b1;
          cnt    <= '0;
          data   <= '0;
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        if (cnt[SUBW-1:0] == SUBW'(MID)) begin
          if (idx == 4'd0) begin
            if (rxs) active <= 1'b0;
          end else if (idx <= dl) begin
            data[idx-4'd1] <= rxs;
          end else if (pon && idx == dl + 4'd1) begin
            pb <= rxs;
          end else begin
            done   <= 1'b1;
            ferr   <= !rxs;
            perr   <= pon && (pb != par_bit(fmt, data[DATA_W-1:0]));
            active <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uft_xcvr.sv
module uft_xcvr
  import uft_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              cfg_nine,
  input  logic              cfg_len8,
  input  logic              cfg_psel1,
  input  logic              cfg_xbit_psel0,
  input  logic              cfg_stop2,
  input  logic              tx_ien,
  input  logic              rx_ien,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_bit9,
  output logic              rx_err_frame,
  output logic              rx_err_parity,
  output logic              rx_err_overrun,
  output logic              tx_irq,
  output logic              rx_irq
);
  fmt_t              fmt;
  logic [DATA_W-1:0] tbuf;
  logic              tfull, take, tx_busy;
  logic              rx_done, f_err, p_err, rd;
  logic [DATA_W:0]   f_data;

  assign fmt = '{nine: cfg_nine, len8: cfg_len8, psel1: cfg_psel1,
                 xbit_psel0: cfg_xbit_psel0, stop2: cfg_stop2};

  uft_tx #(.OVS(OVS)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .fmt(fmt),
    .buf_data(tbuf), .buf_full(tfull), .take(take), .busy(tx_busy), .txd(txd)
  );

  uft_rx #(.OVS(OVS), .SYNC(SYNC)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .fmt(fmt), .rxd(rxd),
    .done(rx_done), .data(f_data), .ferr(f_err), .perr(p_err)
  );

  assign tx_ready = !tfull;
  assign tx_irq   = !tfull && tx_ien;
  assign rd       = rx_valid && rx_ready;
  assign rx_irq   = rx_valid && rx_ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf  <= '0;
      tfull <= 1'b0;
    end else if (tx_valid && !tfull) begin
      tbuf  <= tx_data;
      tfull <= 1'b1;
    end else if (take) begin
      tfull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data        <= '0;
      rx_bit9        <= 1'b0;
      rx_valid       <= 1'b0;
      rx_err_frame   <= 1'b0;
      rx_err_parity  <= 1'b0;
      rx_err_overrun <= 1'b0;
    end else if (rx_done) begin
      if (!rx_valid || rd) begin
        rx_data        <= f_data[DATA_W-1:0];
        rx_bit9        <= f_data[DATA_W];
        rx_err_frame   <= f_err;
        rx_err_parity  <= p_err;
        rx_err_overrun <= 1'b0;
        rx_valid       <= 1'b1;
      end else begin
        rx_err_overrun <= 1'b1;
      end
    end else if (rd) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uft_chk.sv
module uft_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_ien,
  input logic       tx_irq,
  input logic       tx_busy,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_ien,
  input logic       rx_irq,
  input logic [7:0] rx_data,
  input logic       rx_done,
  input logic       rx_err_overrun
);
  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R1
  AST_WRITE_DROPS_TX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_irq && !tx_ready); // R5
  AST_TX_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ien && tx_ready |-> tx_irq); // R5
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !rx_done |=> !rx_valid); // R6
  AST_RX_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ien && rx_valid |-> rx_irq); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_valid && !rx_ready |=> rx_err_overrun && rx_valid); // R10
  AST_RX_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R11
endmodule

bind uft_xcvr uft_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_ien(tx_ien), .tx_irq(tx_irq), .tx_busy(tx_busy), .txd(txd),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ien(rx_ien), .rx_irq(rx_irq),
  .rx_data(rx_data), .rx_done(rx_done), .rx_err_overrun(rx_err_overrun)
);

// File: tb/test_uft_xcvr.sv
module test_uft_xcvr;
  logic clk = 0, rst_n = 0, tdiv = 0;
  logic cfg_nine = 0, cfg_len8 = 1, cfg_psel1 = 0, cfg_xbit_psel0 = 0, cfg_stop2 = 0;
  logic tx_ien = 0, rx_ien = 0, tx_valid = 0, rx_ready = 0, loopback = 1, rxd_drv = 1;
  logic [7:0] tx_data = 0;
  logic tx_ready, txd, rx_valid, rx_bit9, rx_err_frame, rx_err_parity, rx_err_overrun;
  logic tx_irq, rx_irq, rxd, tick16;
  logic [7:0] rx_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= ~tdiv;
  assign tick16 = tdiv;
  assign rxd = loopback ? txd : rxd_drv;

  uft_xcvr i_uft_xcvr (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(negedge clk); while (!tick16);
    end
  endtask

  function automatic void exp_frame(input logic [7:0] d, input logic nine, len8, ps1, ps0, st2,
                                    output logic [11:0] f, output int nb);
    int dl;
    int ones;
    logic [8:0] d9;
    dl = nine ? 9 : (len8 ? 8 : 7);
    d9 = {ps0, d};
    ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) begin
      f[1+i] = d9[i];
      ones += int'(d9[i]);
    end
    nb = 1 + dl;
    if (!nine && {ps1, ps0} != 2'b00) begin
      case ({ps1, ps0})
        2'b01:   f[nb] = (ones % 2 == 0);
        2'b10:   f[nb] = (ones % 2 == 1);
        default: f[nb] = 1'b1;
      endcase
      nb++;
    end
    nb += st2 ? 2 : 1;
  endfunction

  task automatic tx_write(input logic [7:0] d);
    do @(negedge clk); while (!tx_ready);
    tx_data = d;
    tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic tx_capture(input logic [11:0] ef, input int nb, input string req);
    logic [11:0] cap;
    cap = '1;
    do @(negedge clk); while (txd !== 1'b0);
    wait_ticks(8);
    cap[0] = txd;
    for (int i = 1; i < nb; i++) begin
      wait_ticks(16);
      cap[i] = txd;
    end
    chk(req, cap, ef);
  endtask

  task automatic rx_take(output logic [7:0] d, output logic b9, fe, pe, ov);
    do @(negedge clk); while (!rx_valid);
    d = rx_data; b9 = rx_bit9; fe = rx_err_frame; pe = rx_err_parity; ov = rx_err_overrun;
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic send_line(input logic [11:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      rxd_drv = f[i];
      wait_ticks(16);
    end
    rxd_drv = 1;
  endtask

  initial begin
    repeat (1900000 / 10) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] fa, fb, fc;
    int na, nb, nc;
    logic [7:0] d;
    logic b9, fe, pe, ov;
    logic seen_a, seen_b;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 idle line", txd, 1);
    chk("R5 reset empty", tx_ready, 1);
    chk("R6 reset full flag", rx_valid, 0);
    chk("R5 irq off", tx_irq, 0);
    rst_n = 1;
    tx_ien = 1;
    @(negedge clk);
    chk("R5 irq on empty", tx_irq, 1);
    tx_ien = 0;

    // sweep all frame formats in loopback
    for (int c = 0; c < 32; c++) begin
      logic [7:0] a, b;
      logic [7:0] ea, eb;
      {cfg_nine, cfg_len8, cfg_psel1, cfg_xbit_psel0, cfg_stop2} = 5'(c);
      a = 8'((c * 37 + 5) ^ 8'h80);
      b = ~a ^ 8'(c);
      exp_frame(a, cfg_nine, cfg_len8, cfg_psel1, cfg_xbit_psel0, cfg_stop2, fa, na);
      exp_frame(b, cfg_nine, cfg_len8, cfg_psel1, cfg_xbit_psel0, cfg_stop2, fb, nb);
      ea = (cfg_nine || cfg_len8) ? a : (a & 8'h7f);
      eb = (cfg_nine || cfg_len8) ? b : (b & 8'h7f);
      fork
        begin tx_write(a); tx_write(b); end
        begin tx_capture(fa, na, "R1/R2/R3/R4 tx frame A"); tx_capture(fb, nb, "R1/R2/R3/R4 tx frame B"); end
        begin
          rx_take(d, b9, fe, pe, ov);
          chk("R1 rx data A", d, ea);
          chk("R3 rx bit9 A", b9, cfg_nine & cfg_xbit_psel0);
          chk("R8 R9 no errors A", {fe, pe, ov}, 0);
          rx_take(d, b9, fe, pe, ov);
          chk("R1 rx data B", d, eb);
          chk("R3 rx bit9 B", b9, cfg_nine & cfg_xbit_psel0);
          chk("R8 R9 no errors B", {fe, pe, ov}, 0);
        end
      join
    end

    // transmit buffer request while busy
    tx_ien = 1;
    {cfg_nine, cfg_len8, cfg_psel1, cfg_xbit_psel0, cfg_stop2} = 5'b01000;
    tx_write(8'h11);
    tx_write(8'h22);
    chk("R5 buffer full while busy", tx_ready, 0);
    chk("R5 irq removed by write", tx_irq, 0);
    do @(negedge clk); while (!tx_ready);
    chk("R5 irq back when empty", tx_irq, 1);
    tx_ien = 0;
    repeat (2) rx_take(d, b9, fe, pe, ov);
    wait_ticks(200);

    // directed receive cases: 8 bits, even parity, two stop bits programmed
    loopback = 0;
    {cfg_nine, cfg_len8, cfg_psel1, cfg_xbit_psel0, cfg_stop2} = 5'b01101;
    rx_ien = 1;
    exp_frame(8'h5a, 0, 1, 1, 0, 0, fa, na);
    exp_frame(8'hc3, 0, 1, 1, 0, 0, fb, nb);
    fork
      begin send_line(fa, na); send_line(fb, nb); end
      begin
        do @(negedge clk); while (!rx_valid);
        chk("R6 rx irq", rx_irq, 1);
        rx_take(d, b9, fe, pe, ov);
        chk("R4 single stop frame 1", {d, fe, pe, ov}, {8'h5a, 3'b000});
        rx_take(d, b9, fe, pe, ov);
        chk("R4 single stop frame 2", {d, fe, pe, ov}, {8'hc3, 3'b000});
      end
    join
    chk("R6 irq after read", rx_irq, 0);

    fa[9] = ~fa[9];
    send_line(fa, na);
    rx_take(d, b9, fe, pe, ov);
    chk("R9 parity error", {d, fe, pe}, {8'h5a, 2'b01});

    fa[9] = ~fa[9];
    fa[10] = 1'b0;
    send_line(fa, na);
    wait_ticks(16);
    rx_take(d, b9, fe, pe, ov);
    chk("R8 framing error", {d, fe, pe}, {8'h5a, 2'b10});

    rxd_drv = 0;
    wait_ticks(4);
    rxd_drv = 1;
    wait_ticks(200);
    chk("R7 short start rejected", rx_valid, 0);

    // overrun and same-cycle read/complete sweep, 8N1
    {cfg_nine, cfg_len8, cfg_psel1, cfg_xbit_psel0, cfg_stop2} = 5'b01000;
    exp_frame(8'h3c, 0, 1, 0, 0, 0, fa, na);
    exp_frame(8'ha7, 0, 1, 0, 0, 0, fb, nb);
    exp_frame(8'h81, 0, 1, 0, 0, 0, fc, nc);
    send_line(fa, na);
    send_line(fb, nb);
    wait_ticks(20);
    chk("R10 overrun keeps old", {rx_valid, rx_data, rx_err_overrun}, {1'b1, 8'h3c, 1'b1});
    chk("R11 data held", rx_data, 8'h3c);
    rx_take(d, b9, fe, pe, ov);
    send_line(fc, nc);
    rx_take(d, b9, fe, pe, ov);
    chk("R10 overrun cleared on load", {d, ov}, {8'h81, 1'b0});

    seen_a = 0;
    seen_b = 0;
    for (int k = 0; k < 50; k++) begin
      logic oa, obb;
      send_line(fa, na);
      fork
        send_line(fb, nb);
        begin
          repeat (280 + k) @(negedge clk);
          rx_ready = 1;
          @(negedge clk);
          rx_ready = 0;
        end
      join
      wait_ticks(20);
      oa  = rx_valid && rx_data == 8'ha7 && !rx_err_overrun;
      obb = !rx_valid && rx_err_overrun;
      chk("R10 read vs completion outcome", {oa | obb}, 1);
      if (oa && seen_b) chk("R10 outcome order", 0, 1);
      seen_a |= oa;
      seen_b |= obb;
      if (rx_valid) rx_take(d, b9, fe, pe, ov);
    end
    chk("R10 both outcomes seen", {seen_a, seen_b}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule